// File: doc/BRIEF.md
# Receive Buffer Descriptor Ring Engine

This block sits behind a serial receiver and places each arriving byte into host memory. The buffers are chosen from a small ring of descriptors. Each descriptor carries an ownership flag, a wrap flag, two completion flags, a byte count, a length limit and a buffer base address. The engine fetches the current descriptor ahead of the data. If the host has handed that descriptor over, the engine writes bytes one after another into the buffer. It closes the buffer when the buffer is full, when a frame ends or when the receiver reports an error. It then writes the results back, returns ownership to the host and moves on to the next descriptor.

If the host has not freed the descriptor, the engine does not skip ahead. It keeps polling the same entry, drops the bytes that arrive in the meantime and flags each drop as a busy error. In continuous mode the ownership flag is never taken back, so a fixed set of descriptors is refilled indefinitely without host action.

A descriptor is 80 bits wide:
- bits 79:64 are the status word; within it, bit 79 is empty (the engine may fill the buffer), bit 77 is wrap, bit 75 is last and bit 65 is error.
- bits 63:48 are the byte count.
- bits 47:32 are the length limit.
- bits 31:0 are the buffer base address.

Bytes must arrive at least 6 clock cycles apart.

Top module: `rx_bd_ring`

## Requirements
- R1: When `rx_en` is low the engine holds descriptor index 0 and makes no memory access. The cycle after `rx_en` rises, it reads descriptor 0.
- R2: A byte accepted into an open buffer is written to data address base + count. The data write appears one cycle after the byte, and each following byte takes the next address.
- R3: If the fetched descriptor has bit 79 clear, the engine stores nothing and polls the same index until the bit is set. Each byte arriving in that time is dropped and gives a one-cycle `busy_err` pulse.
- R4: A buffer closes when its count reaches the length limit. The written-back count (bits 63:48) equals the number of bytes stored.
- R5: A buffer closed by `in_eof` has last (bit 75) set on write-back; a buffer closed for any other reason has it clear.
- R6: A buffer closed by `in_err` has error (bit 65) set on write-back; a buffer closed for any other reason has it clear.
- R7: When continuous mode is off, a close issues two descriptor writes to the same index. The first keeps bit 79 set and carries the count and flags. The second, in the next cycle, clears bit 79.
- R8: After a close, the next descriptor is index 0 if the closed one had wrap set or was entry NDESC-1. Otherwise it is the following index.
- R9: In continuous mode the close issues only the first write, with bit 79 left set, so the same descriptor is refilled again.
- R10: `overrun` becomes 1 when a byte is dropped and stays 1 until a descriptor is next opened with bit 79 set.
- R11: Each closed buffer gives exactly one `irq` pulse, one cycle long, in the cycle after the last descriptor write of that close.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enable; low resets the ring index |
| cont_mode | input | 1 | Continuous mode, ownership is never returned |
| in_valid | input | 1 | Received byte strobe |
| in_data | input | 8 | Received byte |
| in_eof | input | 1 | Byte is the last of a frame |
| in_err | input | 1 | Receiver detected an error with this byte |
| bd_rd | output | 1 | Descriptor read request |
| bd_we | output | 1 | Descriptor write enable |
| bd_addr | output | $clog2(NDESC) | Descriptor index |
| bd_wdata | output | 80 | Descriptor write data |
| bd_rdata | input | 80 | Descriptor read data, valid the cycle after `bd_rd` |
| dm_we | output | 1 | Data memory write enable |
| dm_addr | output | 32 | Data memory byte address |
| dm_wdata | output | 8 | Data memory write byte |
| irq | output | 1 | One-cycle pulse per closed buffer |
| busy_err | output | 1 | One-cycle pulse per byte dropped on a host-owned descriptor |
| overrun | output | 1 | Sticky dropped-byte indication |

## Verification
A long random byte stream is driven through rings with random length limits. Random end-of-frame and error markers are mixed in, so each close cause is told apart by the last and error flags written back. One pass wraps the ring early through a wrap flag and another runs off the end of the table, which separates the two rules for choosing the next index. Directed cases present a host-owned first descriptor: they check that bytes are dropped with busy pulses, that the overrun flag is sticky and that the engine resumes on the same entry once the host frees it. A continuous-mode case checks that the descriptor is refilled with no release write.

// File: rtl/rx_bd_ring.sv
module rx_bd_ring #(
  parameter int NDESC = 8,
  localparam int IW = $clog2(NDESC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          cont_mode,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_eof,
  input  logic          in_err,
  output logic          bd_rd,
  output logic          bd_we,
  output logic [IW-1:0] bd_addr,
  output logic [79:0]   bd_wdata,
  input  logic [79:0]   bd_rdata,
  output logic          dm_we,
  output logic [31:0]   dm_addr,
  output logic [7:0]    dm_wdata,
  output logic          irq,
  output logic          busy_err,
  output logic          overrun
);
  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CHECK, S_READY, S_WB, S_REL} st_t;

  st_t          st;
  logic [IW-1:0] idx;
  logic [15:0]  sts, cnt, lim;
  logic [31:0]  base;
  logic         cl_eof, cl_err, busy;

  wire [15:0]   cnt_nx   = cnt + 16'd1;
  wire          closes   = in_eof || in_err || (cnt_nx >= lim);
  wire          last_idx = (idx == IW'(NDESC - 1));
  wire [IW-1:0] idx_nx   = (sts[13] || last_idx) ? '0 : idx + 1'b1;
  wire [15:0]   sts_wb   = {1'b1, sts[14:12], cl_eof, sts[10:2], cl_err, sts[0]};

  assign bd_rd    = (st == S_FETCH);
  assign bd_we    = (st == S_WB) || (st == S_REL);
  assign bd_addr  = idx;
  assign bd_wdata = {(st == S_WB) ? sts_wb : {1'b0, sts_wb[14:0]}, cnt, lim, base};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      idx      <= '0;
      sts      <= '0;
      cnt      <= '0;
      lim      <= '0;
      base     <= '0;
      cl_eof   <= 1'b0;
      cl_err   <= 1'b0;
      busy     <= 1'b0;
      dm_we    <= 1'b0;
      dm_addr  <= '0;
      dm_wdata <= '0;
      irq      <= 1'b0;
      busy_err <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      irq      <= 1'b0;
      busy_err <= 1'b0;
      dm_we    <= 1'b0;
      if (!rx_en) begin
        st   <= S_IDLE;
        idx  <= '0;
        busy <= 1'b0;
      end else begin
        case (st)
          S_IDLE:  st <= S_FETCH;
          S_FETCH: st <= S_CHECK;
          S_CHECK: begin
            sts  <= bd_rdata[79:64];
            lim  <= bd_rdata[47:32];
            base <= bd_rdata[31:0];
            cnt  <= '0;
            if (bd_rdata[79]) begin
              st      <= S_READY;
              busy    <= 1'b0;
              overrun <= 1'b0;
            end else begin
              st   <= S_FETCH;
              busy <= 1'b1;
            end
          end
          S_READY: if (in_valid) begin
            dm_we    <= 1'b1;
            dm_addr  <= base + 32'(cnt);
            dm_wdata <= in_data;
            cnt      <= cnt_nx;
            if (closes) begin
              st     <= S_WB;
              cl_eof <= in_eof;
              cl_err <= in_err;
            end
          end
          S_WB: if (cont_mode) begin
            st  <= S_FETCH;
            idx <= idx_nx;
            irq <= 1'b1;
          end else begin
            st <= S_REL;
          end
          S_REL: begin
            st  <= S_FETCH;
            idx <= idx_nx;
            irq <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
        if (in_valid && st != S_READY) begin
          overrun  <= 1'b1;
          busy_err <= busy;
        end
      end
    end
  end
endmodule

// File: rtl/rx_bd_ring_chk.sv
module rx_bd_ring_chk #(
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          cont_mode,
  input logic          in_valid,
  input logic          bd_rd,
  input logic          bd_we,
  input logic [IW-1:0] bd_addr,
  input logic [79:0]   bd_wdata,
  input logic          dm_we,
  input logic          irq,
  input logic          busy_err,
  input logic          overrun
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (bd_addr == '0 && !bd_rd && !bd_we));

  assert_port_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bd_rd && bd_we));

  assert_data_follows_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dm_we |-> $past(in_valid));

  assert_release_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bd_we && !bd_wdata[79]) |-> ($past(bd_we) && $past(bd_wdata[79]) && $past(bd_addr) == bd_addr));

  assert_cont_keeps_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_mode && $past(cont_mode) && bd_we) |-> bd_wdata[79]);

  assert_busy_sets_overrun_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err |-> overrun);

  assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  assert_irq_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(bd_we));
endmodule

bind rx_bd_ring rx_bd_ring_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cont_mode(cont_mode),
  .in_valid(in_valid), .bd_rd(bd_rd), .bd_we(bd_we), .bd_addr(bd_addr),
  .bd_wdata(bd_wdata), .dm_we(dm_we), .irq(irq), .busy_err(busy_err),
  .overrun(overrun)
);

// File: tb/rx_bd_ring_tb.sv
module rx_bd_ring_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NDESC = 8;
  localparam int IW = $clog2(NDESC);

  logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0, cont_mode = 1'b0;
  logic in_valid = 1'b0, in_eof = 1'b0, in_err = 1'b0;
  logic [7:0] in_data = '0;
  logic bd_rd, bd_we, dm_we, irq, busy_err, overrun;
  logic [IW-1:0] bd_addr;
  logic [79:0] bd_wdata, bd_rdata;
  logic [31:0] dm_addr;
  logic [7:0] dm_wdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_bd_ring #(.NDESC(NDESC)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .cont_mode(cont_mode),
    .in_valid(in_valid), .in_data(in_data), .in_eof(in_eof), .in_err(in_err),
    .bd_rd(bd_rd), .bd_we(bd_we), .bd_addr(bd_addr), .bd_wdata(bd_wdata),
    .bd_rdata(bd_rdata), .dm_we(dm_we), .dm_addr(dm_addr), .dm_wdata(dm_wdata),
    .irq(irq), .busy_err(busy_err), .overrun(overrun)
  );

  logic [79:0] bdm [NDESC];
  logic [7:0]  dmem [4096];
  always @(posedge clk) begin
    if (bd_we) bdm[bd_addr] <= bd_wdata;
    if (bd_rd) bd_rdata <= bdm[bd_addr];
    if (dm_we) dmem[dm_addr[11:0]] <= dm_wdata;
  end

  int checks = 0, fails = 0;
  int n_irq = 0, n_busy = 0, n_rel = 0;
  bit done = 0;
  logic prev_we = 0, prev_e = 0;
  logic [IW-1:0] prev_a = '0;

  task automatic chk(input bit ok, input string rq, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (irq) n_irq++;
      if (busy_err) n_busy++;
      if (bd_we && !bd_wdata[79]) begin
        n_rel++;
        chk(prev_we && prev_e && prev_a == bd_addr, "R7 release order", {79'd0, prev_we}, 80'd1);
      end
    end
    prev_we = bd_we; prev_e = bd_wdata[79]; prev_a = bd_addr;
  end

  function automatic logic [79:0] mk_desc(bit e, bit w, logic [15:0] l, logic [31:0] b);
    return {e, 1'b0, w, 13'd0, 16'd0, l, b};
  endfunction

  function automatic int next_idx(int i, bit w);
    return (w || i == NDESC - 1) ? 0 : i + 1;
  endfunction

  task automatic send(input logic [7:0] d, input bit eof, input bit err);
    @(negedge clk);
    in_valid = 1; in_data = d; in_eof = eof; in_err = err;
    @(negedge clk);
    in_valid = 0; in_eof = 0; in_err = 0;
    repeat (7) @(negedge clk);
  endtask

  int lims [NDESC];
  bit wraps [NDESC];

  task automatic run_random(input int nbytes, input int wrap_at);
    int m = 0, mc = 0;
    rx_en = 0;
    @(negedge clk);
    for (int i = 0; i < NDESC; i++) begin
      lims[i] = 1 + int'($urandom % 5);
      wraps[i] = (i == wrap_at);
      bdm[i] = mk_desc(1, wraps[i], 16'(lims[i]), 32'(i * 256));
    end
    rx_en = 1;
    @(negedge clk);
    chk(bd_rd && bd_addr == '0, "R1 first fetch", {76'd0, bd_rd, bd_addr}, {76'd0, 1'b1, 3'd0});
    repeat (4) @(negedge clk);
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] d;
      int r, irq0, addr;
      bit eof, err, cl;
      logic [79:0] dsc;
      d = 8'($urandom); r = int'($urandom % 8);
      eof = (r == 0); err = (r == 1);
      addr = m * 256 + mc;
      mc++;
      cl = eof || err || mc >= lims[m];
      irq0 = n_irq;
      send(d, eof, err);
      chk(dmem[addr] == d, "R2 data placement", {72'd0, dmem[addr]}, {72'd0, d});
      if (cl) begin
        dsc = bdm[m];
        chk(dsc[79] == 1'b0, "R7 ownership returned", {79'd0, dsc[79]}, 80'd0);
        chk(dsc[63:48] == 16'(mc), "R4 count", {64'd0, dsc[63:48]}, 80'(mc));
        chk(dsc[75] == eof, "R5 last flag", {79'd0, dsc[75]}, {79'd0, eof});
        chk(dsc[65] == err, "R6 error flag", {79'd0, dsc[65]}, {79'd0, err});
        chk(n_irq == irq0 + 1, "R11 irq per close", 80'(n_irq), 80'(irq0 + 1));
        bdm[m] = mk_desc(1, wraps[m], 16'(lims[m]), 32'(m * 256));
        m = next_idx(m, wraps[m]);  // R8 next data check lands at this base
        mc = 0;
      end else begin
        chk(n_irq == irq0, "R11 no irq without close", 80'(n_irq), 80'(irq0));
      end
    end
    rx_en = 0;
    @(negedge clk);
    chk(bd_addr == '0 && !bd_rd && !bd_we, "R1 disable resets index", 80'(bd_addr), 80'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int b0, r0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 4096; i++) dmem[i] = 8'h00;
    for (int i = 0; i < NDESC; i++) bdm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!irq && !busy_err && !overrun && !bd_we && !bd_rd && !dm_we, "R1 reset state",
        {74'd0, irq, busy_err, overrun, bd_we, bd_rd, dm_we}, 80'd0);

    run_random(120, 5);
    run_random(120, -1);

    // R3 / R10: host-owned first descriptor
    for (int i = 0; i < NDESC; i++) bdm[i] = mk_desc(1, 0, 16'd4, 32'(i * 256));
    bdm[0] = mk_desc(0, 0, 16'd4, 32'd0);
    dmem[0] = 8'h00;
    b0 = n_busy;
    rx_en = 1;
    repeat (4) @(negedge clk);
    send(8'hA5, 1, 0);
    chk(n_busy == b0 + 1, "R3 busy pulse", 80'(n_busy), 80'(b0 + 1));
    chk(overrun == 1'b1, "R10 overrun set", {79'd0, overrun}, 80'd1);
    chk(dmem[0] == 8'h00, "R3 byte dropped", {72'd0, dmem[0]}, 80'd0);
    chk(bd_addr == '0, "R3 stays on index", 80'(bd_addr), 80'd0);
    repeat (10) @(negedge clk);
    chk(overrun == 1'b1, "R10 overrun sticky", {79'd0, overrun}, 80'd1);
    bdm[0] = mk_desc(1, 0, 16'd4, 32'd0);
    repeat (4) @(negedge clk);
    chk(overrun == 1'b0, "R10 overrun cleared on open", {79'd0, overrun}, 80'd0);
    send(8'h3C, 1, 0);
    chk(dmem[0] == 8'h3C, "R3 resumes same descriptor", {72'd0, dmem[0]}, 80'h3C);
    chk(bdm[0][63:48] == 16'd1 && bdm[0][75], "R5 close after resume", bdm[0], 80'd0);
    rx_en = 0;
    @(negedge clk);

    // R9: continuous mode
    cont_mode = 1;
    bdm[0] = mk_desc(1, 1, 16'd2, 32'h40);
    r0 = n_rel;
    @(negedge clk);
    rx_en = 1;
    repeat (4) @(negedge clk);
    send(8'h11, 0, 0);
    send(8'h22, 0, 0);
    chk(bdm[0][79] == 1'b1, "R9 empty kept", {79'd0, bdm[0][79]}, 80'd1);
    chk(bdm[0][63:48] == 16'd2, "R4 count in continuous", {64'd0, bdm[0][63:48]}, 80'd2);
    chk(n_rel == r0, "R9 no release write", 80'(n_rel), 80'(r0));
    send(8'h33, 0, 0);
    chk(dmem[12'h40] == 8'h33, "R9 descriptor reused", {72'd0, dmem[12'h40]}, 80'h33);
    rx_en = 0; cont_mode = 0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule